// File: doc/BRIEF.md
# LNB Supply Control Sequencer

This block is the digital controller of a satellite low-noise-block supply. It takes the control bits that a register interface has already decoded (supply enable, high/low level select, cable-drop compensation, tone enable, current-limit mode). It also takes a modulation pin, the start and stop indications of an undervoltage comparator pair and an over-temperature flag. From these it decides when the boost converter and linear regulator may run, and it produces the output-voltage code for the reference.

Each time the supply starts it runs a fixed-length digital soft-start ramp. It also produces a square-wave signalling tone by dividing the converter oscillator clock by ten. The tone is requested either by the register bit or by the modulation pin. The over-temperature flag is copied into a status bit that software can read. Everything runs on the converter oscillator clock.

Top module: `lnb_ctrl_seq`

## Requirements
- R1: While rst_n is low, and at the first sample after it rises, every output is 0 and the undervoltage state is "not started".
- R2: The undervoltage state becomes "started" on the clock edge where uv_start is high. It becomes "stopped" on the edge where uv_stop is high, and uv_stop wins when both are high. pwm_en and lin_en rise one edge after the state becomes started, provided the supply is enabled and no thermal fault is present.
- R3: If ctl_enable is low at a clock edge, pwm_en and lin_en are low after the next edge.
- R4: If temp_fault is high at a clock edge, pwm_en and lin_en are low after the next edge, and stat_overtemp equals temp_fault delayed by one edge.
- R5: vref_code is the output level in whole volts as an unsigned binary number. It is 13 for sel_high=0/comp_add=0, 14 for 0/1, 18 for 1/0 and 19 for 1/1. It is 0 whenever pwm_en is 0.
- R6: While running, ss_ramp rises by one per clock from 0 up to 1024 and then holds. ss_done is high exactly when ss_ramp is 1024.
- R7: Any shutdown (enable low, thermal fault or undervoltage) clears ss_ramp to 0, so the next run starts a fresh 1024-step ramp.
- R8: A change of sel_high or comp_add while running changes vref_code one edge later and leaves ss_ramp counting without a restart.
- R9: While a tone is requested, tone_out has a period of 10 clocks: 5 clocks high, then 5 low.
- R10: A tone is requested while the supply runs and either tone_req_reg or tone_mod_pin is high. Otherwise tone_out is 0.
- R11: When the request drops, tone_out goes low one edge later and the divider returns to its start. Every new burst therefore begins with a full 5-clock high phase.
- R12: ilim_static equals ctl_ilim_static delayed by one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_enable | input | 1 | Supply enable bit (low = standby) |
| sel_high | input | 1 | Level select: 0 = 13 V, 1 = 18 V |
| comp_add | input | 1 | Adds 1 V for cable drop |
| tone_req_reg | input | 1 | Register tone request |
| ctl_ilim_static | input | 1 | Current-limit mode bit |
| tone_mod_pin | input | 1 | External tone modulation pin |
| uv_start | input | 1 | Undervoltage start-threshold indication |
| uv_stop | input | 1 | Undervoltage stop-threshold indication |
| temp_fault | input | 1 | Over-temperature flag |
| pwm_en | output | 1 | Boost converter enable |
| lin_en | output | 1 | Linear regulator enable |
| vref_code | output | 5 | Output-level code in volts |
| ss_ramp | output | 11 | Soft-start ramp value |
| ss_done | output | 1 | Ramp complete |
| tone_out | output | 1 | Tone square wave |
| stat_overtemp | output | 1 | Over-temperature status bit |
| ilim_static | output | 1 | Registered current-limit mode |

## Verification
A wrong undervoltage or run state shows on pwm_en, vref_code and ss_ramp within two clocks of the stimulus that exposes it. A soft-start counter that is not cleared, or that is restarted, shows as a ss_ramp mismatch on the very next clock and again 1024 clocks later on ss_done. A divider that is off by a phase or not cleared shows within one tone period, and a burst started mid-period shows on its first edge. The reference model in the bench is compared with every output on every clock, so the first cycle of divergence is the one that gets reported.

// File: rtl/lnb_seq_pkg.sv
package lnb_seq_pkg;

    typedef struct packed {
        logic enable;
        logic sel_high;
        logic comp_add;
        logic tone_req;
        logic ilim_static;
    } lnb_ctrl_t;

    typedef enum logic {
        UV_OFF = 1'b0,
        UV_ON  = 1'b1
    } uv_state_e;

endpackage

// File: rtl/lnb_uvlo.sv
module lnb_uvlo
    import lnb_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    output logic ok_o
);
    typedef struct packed {
        uv_state_e st;
    } uv_regs_t;

    uv_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (stop_i) begin
            r_d.st = UV_OFF;
        end else if (start_i) begin
            r_d.st = UV_ON;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: UV_OFF};
        end else begin
            r_q <= r_d;
        end
    end

    assign ok_o = (r_q.st == UV_ON);
endmodule

// File: rtl/lnb_softstart.sv
module lnb_softstart #(
    parameter int RAMP_CYCLES = 1024,
    localparam int RAMP_W = $clog2(RAMP_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    output logic [RAMP_W-1:0] ramp_o,
    output logic              done_o
);
    localparam logic [RAMP_W-1:0] RAMP_TOP = RAMP_W'(RAMP_CYCLES);

    typedef struct packed {
        logic [RAMP_W-1:0] cnt;
    } ss_regs_t;

    ss_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!run_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt != RAMP_TOP) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ramp_o = r_q.cnt;
    assign done_o = (r_q.cnt == RAMP_TOP);
endmodule

// File: rtl/lnb_tone_div.sv
module lnb_tone_div #(
    parameter int DIV = 10,
    localparam int CNT_W = $clog2(DIV),
    localparam int HALF = DIV / 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic tone_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);
    localparam logic [CNT_W-1:0] HI_END = CNT_W'(HALF);

    typedef struct packed {
        logic [CNT_W-1:0] phase;
        logic             wave;
    } td_regs_t;

    td_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!req_i) begin
            r_d.phase = '0;
            r_d.wave  = 1'b0;
        end else begin
            r_d.wave  = (r_q.phase < HI_END);
            r_d.phase = (r_q.phase == LAST) ? '0 : r_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign tone_o = r_q.wave;
endmodule

// File: rtl/lnb_ctrl_seq.sv
module lnb_ctrl_seq
    import lnb_seq_pkg::*;
#(
    parameter int VCODE_W     = 5,
    parameter int V_LOW       = 13,
    parameter int V_HIGH      = 18,
    parameter int V_COMP      = 1,
    parameter int RAMP_CYCLES = 1024,
    parameter int TONE_DIV    = 10,
    localparam int RAMP_W = $clog2(RAMP_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_enable,
    input  logic               sel_high,
    input  logic               comp_add,
    input  logic               tone_req_reg,
    input  logic               ctl_ilim_static,
    input  logic               tone_mod_pin,
    input  logic               uv_start,
    input  logic               uv_stop,
    input  logic               temp_fault,
    output logic               pwm_en,
    output logic               lin_en,
    output logic [VCODE_W-1:0] vref_code,
    output logic [RAMP_W-1:0]  ss_ramp,
    output logic               ss_done,
    output logic               tone_out,
    output logic               stat_overtemp,
    output logic               ilim_static
);
    typedef struct packed {
        logic               pwr_on;
        logic [VCODE_W-1:0] code;
        logic               otf;
        logic               ilim;
    } top_regs_t;

    lnb_ctrl_t  ctl;
    logic       uv_ok;
    logic       run;
    logic       tone_req;
    top_regs_t  r_d, r_q;

    always_comb begin
        ctl.enable      = ctl_enable;
        ctl.sel_high    = sel_high;
        ctl.comp_add    = comp_add;
        ctl.tone_req    = tone_req_reg;
        ctl.ilim_static = ctl_ilim_static;
    end

    lnb_uvlo u_uvlo (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (uv_start),
        .stop_i  (uv_stop),
        .ok_o    (uv_ok)
    );

    assign run      = ctl.enable & uv_ok & ~temp_fault;
    assign tone_req = run & (ctl.tone_req | tone_mod_pin);

    lnb_softstart #(.RAMP_CYCLES(RAMP_CYCLES)) u_ss (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .ramp_o (ss_ramp),
        .done_o (ss_done)
    );

    lnb_tone_div #(.DIV(TONE_DIV)) u_tone (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (tone_req),
        .tone_o (tone_out)
    );

    always_comb begin
        r_d        = r_q;
        r_d.pwr_on = run;
        r_d.otf    = temp_fault;
        r_d.ilim   = ctl.ilim_static;
        if (run) begin
            r_d.code = (ctl.sel_high ? VCODE_W'(V_HIGH) : VCODE_W'(V_LOW))
                     + (ctl.comp_add ? VCODE_W'(V_COMP) : VCODE_W'(0));
        end else begin
            r_d.code = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwm_en        = r_q.pwr_on;
    assign lin_en        = r_q.pwr_on;
    assign vref_code     = r_q.code;
    assign stat_overtemp = r_q.otf;
    assign ilim_static   = r_q.ilim;
endmodule

// File: rtl/lnb_ctrl_seq_chk.sv
module lnb_ctrl_seq_chk #(
    parameter int VCODE_W     = 5,
    parameter int RAMP_CYCLES = 1024,
    parameter int RAMP_W      = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctl_enable,
    input logic               uv_stop,
    input logic               temp_fault,
    input logic               ctl_ilim_static,
    input logic               pwm_en,
    input logic               lin_en,
    input logic [VCODE_W-1:0] vref_code,
    input logic [RAMP_W-1:0]  ss_ramp,
    input logic               ss_done,
    input logic               tone_out,
    input logic               stat_overtemp,
    input logic               ilim_static
);
    localparam logic [RAMP_W-1:0] TOP = RAMP_W'(RAMP_CYCLES);

    a_r3_standby_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> (!pwm_en && !lin_en));

    a_r4_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        temp_fault |=> (!pwm_en && stat_overtemp));

    a_r2_uv_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
        uv_stop |-> ##2 !pwm_en);

    a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_en |-> (vref_code == 5'd13 || vref_code == 5'd14 ||
                    vref_code == 5'd18 || vref_code == 5'd19));

    a_r5_code_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |-> (vref_code == '0));

    a_r7_ramp_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |-> (ss_ramp == '0));

    a_r6_ramp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_en && ss_ramp != TOP) |=> (!pwm_en || ss_ramp == $past(ss_ramp) + 1'b1));

    a_r6_ramp_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_ramp <= TOP) && (ss_done == (ss_ramp == TOP)));

    a_r10_tone_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |-> !tone_out);

    a_r12_ilim_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ilim_static == $past(ctl_ilim_static)));
endmodule

bind lnb_ctrl_seq lnb_ctrl_seq_chk #(
    .VCODE_W     (VCODE_W),
    .RAMP_CYCLES (RAMP_CYCLES),
    .RAMP_W      (RAMP_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctl_enable      (ctl_enable),
    .uv_stop         (uv_stop),
    .temp_fault      (temp_fault),
    .ctl_ilim_static (ctl_ilim_static),
    .pwm_en          (pwm_en),
    .lin_en          (lin_en),
    .vref_code       (vref_code),
    .ss_ramp         (ss_ramp),
    .ss_done         (ss_done),
    .tone_out        (tone_out),
    .stat_overtemp   (stat_overtemp),
    .ilim_static     (ilim_static)
);

// File: tb/lnb_ctrl_seq_test.sv
`timescale 1ns/1ps
module lnb_ctrl_seq_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_enable = 0, sel_high = 0, comp_add = 0, tone_req_reg = 0;
    logic ctl_ilim_static = 0, tone_mod_pin = 0, uv_start = 0, uv_stop = 0, temp_fault = 0;
    logic        pwm_en, lin_en, ss_done, tone_out, stat_overtemp, ilim_static;
    logic [4:0]  vref_code;
    logic [10:0] ss_ramp;

    always #2 clk = ~clk;

    lnb_ctrl_seq uut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .sel_high(sel_high),
        .comp_add(comp_add), .tone_req_reg(tone_req_reg), .ctl_ilim_static(ctl_ilim_static),
        .tone_mod_pin(tone_mod_pin), .uv_start(uv_start), .uv_stop(uv_stop),
        .temp_fault(temp_fault), .pwm_en(pwm_en), .lin_en(lin_en), .vref_code(vref_code),
        .ss_ramp(ss_ramp), .ss_done(ss_done), .tone_out(tone_out),
        .stat_overtemp(stat_overtemp), .ilim_static(ilim_static)
    );

    // behavioural reference model
    int m_uv, m_pwr, m_code, m_ramp, m_phase, m_tone, m_otf, m_ilim;
    int vectors = 0, errors = 0;
    string phase = "R1 reset";
    bit finished = 0;

    initial begin
        m_uv = 0; m_pwr = 0; m_code = 0; m_ramp = 0; m_phase = 0; m_tone = 0; m_otf = 0; m_ilim = 0;
    end

    always @(posedge clk or negedge rst_n) begin
        int run;
        if (!rst_n) begin
            m_uv = 0; m_pwr = 0; m_code = 0; m_ramp = 0; m_phase = 0; m_tone = 0; m_otf = 0; m_ilim = 0;
        end else begin
            run = (ctl_enable && m_uv && !temp_fault) ? 1 : 0;
            m_pwr = run;
            m_code = run ? ((sel_high ? 18 : 13) + (comp_add ? 1 : 0)) : 0;
            if (!run) m_ramp = 0;
            else if (m_ramp < 1024) m_ramp = m_ramp + 1;
            if (run && (tone_req_reg || tone_mod_pin)) begin
                m_tone = (m_phase < 5) ? 1 : 0;
                m_phase = (m_phase + 1) % 10;
            end else begin
                m_tone = 0; m_phase = 0;
            end
            m_otf = temp_fault;
            m_ilim = ctl_ilim_static;
            if (uv_stop) m_uv = 0;
            else if (uv_start) m_uv = 1;
        end
    end

    task automatic cmp(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmp("pwm_en R3", pwm_en, m_pwr);
            cmp("lin_en R3", lin_en, m_pwr);
            cmp("vref_code R5", vref_code, m_code);
            cmp("ss_ramp R6", ss_ramp, m_ramp);
            cmp("ss_done R6", ss_done, m_ramp == 1024);
            cmp("tone_out R9", tone_out, m_tone);
            cmp("stat_overtemp R4", stat_overtemp, m_otf);
            cmp("ilim_static R12", ilim_static, m_ilim);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        step(3);
        cmp("R1 pwm_en at reset", pwm_en, 0);
        cmp("R1 tone_out at reset", tone_out, 0);
        rst_n = 1;
        step(2);
        cmp("R1 vref_code after reset", vref_code, 0);

        // R2: enabled but not started stays off
        phase = "R2 waiting for start";
        ctl_enable = 1;
        step(20);
        cmp("R2 still off before start", pwm_en, 0);
        uv_start = 1; step(1); uv_start = 0;
        step(1);
        cmp("R2 on after start", pwm_en, 1);

        // R6: full ramp, with R12 toggles
        phase = "R6 ramp";
        step(500);
        ctl_ilim_static = 1; step(3); ctl_ilim_static = 0;
        // R8: level changes mid-ramp
        phase = "R8 level change";
        sel_high = 1; step(5);
        comp_add = 1; step(5);
        sel_high = 0; step(5);
        phase = "R6 ramp hold";
        step(560);
        cmp("R6 ramp done", ss_done, 1);

        // R10/R9: tone via register, then via pin
        phase = "R10 tone via register";
        tone_req_reg = 1; step(37);
        phase = "R11 tone stop and restart";
        tone_req_reg = 0; step(4);
        phase = "R10 tone via pin";
        tone_mod_pin = 1; step(23);
        tone_mod_pin = 0; step(3);
        tone_mod_pin = 1; step(7);
        tone_req_reg = 1; step(5);
        tone_mod_pin = 0; step(8);

        // R4: thermal fault with tone running
        phase = "R4 thermal";
        temp_fault = 1; step(4); temp_fault = 0;
        phase = "R7 fresh ramp after thermal";
        step(40);

        // R3: standby
        phase = "R3 standby";
        ctl_enable = 0; step(6);
        cmp("R3 standby off", pwm_en, 0);
        ctl_enable = 1;
        phase = "R7 fresh ramp after standby";
        step(30);
        tone_req_reg = 0;

        // R2: stop beats start, then undervoltage restart
        phase = "R2 stop beats start";
        uv_start = 1; uv_stop = 1; step(1); uv_start = 0; uv_stop = 0;
        step(5);
        cmp("R2 stop wins", pwm_en, 0);
        uv_start = 1; step(1); uv_start = 0;
        phase = "R7 fresh ramp after undervoltage";
        sel_high = 1; comp_add = 0;
        step(1100);
        uv_stop = 1; step(1); uv_stop = 0;
        step(5);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule